// File: doc/BRIEF.md
# PHY Training Mailbox Reader

This block is the host side of the message channel between a DRAM PHY's training microcontroller and the rest of the chip. The two sides exchange messages through a pair of protect flags held in PHY registers. The microcontroller clears its flag once a message is posted. The host reads the message, acknowledges it by clearing its own flag, waits for the microcontroller to raise its flag again, and then sets its own flag to close the exchange. The block carries out every step as 16-bit register transfers on an APB-style bus, and it holds each bus transfer until the PHY signals ready.

One `start` pulse runs one of two kinds of session. The first receives a single message and stops. The second keeps receiving messages until one of them reports the end of training. A message is either one 16-bit word or, in streaming mode, a 32-bit value built from two words. An optional arming step writes 1 to both protect registers before the first poll. Each received message appears on `msg_data` together with a one-cycle `msg_valid`. A training-end code raises `train_pass` or `train_fail`, and that flag holds until the next accepted start.

Top module: `phy_mbox_reader`

## Requirements
- R1: Each bus transfer has a setup cycle (psel=1, penable=0) and then access cycles (psel=1, penable=1). The transfer ends at the first access cycle with pready=1, and address, direction and write data stay stable throughout the transfer. The byte address is the register's halfword index shifted left by one. The indices used are 0xD0004 (device flag shadow, byte 0x1A0008), 0xD0031 (host flag, 0x1A0062), 0xD0032 (message low word, 0x1A0064), 0xD0033 (device flag, 0x1A0066) and 0xD0034 (message high word, 0x1A0068). No other address is ever accessed.
- R2: Before reading a message, the block reads 0xD0004 repeatedly until bit 0 reads 0.
- R3: The message low word is read from 0xD0032 and forms `msg_data[15:0]`. In 16-bit mode, `msg_data[31:16]` is zero.
- R4: In streaming mode, 0xD0034 is also read, and its value forms `msg_data[31:16]`.
- R5: After the reads, the block writes 0 to 0xD0031, polls 0xD0004 until bit 0 reads 1, and then writes 1 to 0xD0031. Only after that final write does `msg_valid` pulse for exactly one cycle with the message on `msg_data`.
- R6: With wait-for-end set, messages are received one after another until `msg_data[15:0]` equals 0x0007 or 0x00FF. The upper half takes no part in this comparison, and no further message is fetched after a terminating one.
- R7: A message whose low word is 0x0007 sets `train_pass`, and one whose low word is 0x00FF sets `train_fail`, in either session kind. The two flags are never high together, and both stay set until cleared by the next accepted start.
- R8: With `arm_en` high at start, the first two transfers are writes of 1, first to 0xD0031 and then to 0xD0033, and only after them does polling begin.
- R9: `start` is ignored while `busy` is high. `stream_mode`, `wait_end` and `arm_en` are sampled only when a start is accepted.
- R10: After reset, psel, penable, busy, msg_valid, train_pass and train_fail are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a session (pulse) |
| stream_mode | input | 1 | 1: 32-bit messages, 0: 16-bit messages |
| wait_end | input | 1 | 1: loop until a training-end code |
| arm_en | input | 1 | 1: write both protect registers to 1 first |
| psel | output | 1 | Bus select |
| penable | output | 1 | Bus access phase |
| pwrite | output | 1 | Bus direction, 1 = write |
| paddr | output | ADDR_W | Bus byte address |
| pwdata | output | 16 | Bus write data |
| prdata | input | 16 | Bus read data |
| pready | input | 1 | Bus transfer completion |
| msg_data | output | 32 | Last received message |
| msg_valid | output | 1 | One-cycle pulse per message |
| busy | output | 1 | Session in progress |
| train_pass | output | 1 | Training success code seen |
| train_fail | output | 1 | Training failure code seen |

## Verification
The assertions check the following on every cycle:
- the bus phase order and the stability of a stalled transfer;
- that the sequencer requests a transfer only while the bus engine is idle;
- that polling continues while the flag bit has the wrong value;
- that session modes stay frozen while busy;
- that valid is a single-cycle pulse and pass and fail are exclusive.

The exact order of the handshake writes and the halfword-to-byte address mapping are shown only by the bench's PHY model. That model advances its mailbox solely when the protocol is followed. The same holds for the assembled 16- and 32-bit message values, loop termination on the low word alone, and the arming order, all of which only the bench's scenarios can show.

// File: rtl/mbox_pkg.sv
// Package: shared constants, register indices and sequencer states for the
// PHY mailbox reader. Indices are halfword numbers; byte address = index << 1.
package mbox_pkg;
    localparam int IDX_W = 20;
    localparam int HW_W  = 16;
    localparam int MSG_W = 2 * HW_W;

    localparam logic [IDX_W-1:0] IDX_DEV_SHADOW = 20'hD0004;
    localparam logic [IDX_W-1:0] IDX_HOST_FLAG  = 20'hD0031;
    localparam logic [IDX_W-1:0] IDX_MSG_LO     = 20'hD0032;
    localparam logic [IDX_W-1:0] IDX_DEV_FLAG   = 20'hD0033;
    localparam logic [IDX_W-1:0] IDX_MSG_HI     = 20'hD0034;

    localparam logic [HW_W-1:0] CODE_PASS = 16'h0007;
    localparam logic [HW_W-1:0] CODE_FAIL = 16'h00FF;

    typedef enum logic [3:0] {
        S_IDLE, S_ARM_H, S_ARM_D, S_POLL_LO, S_RD_LO,
        S_RD_HI, S_ACK, S_POLL_HI, S_FIN
    } seq_state_t;

    // True when a message low word ends a training session.
    function automatic logic is_term(input logic [HW_W-1:0] code);
        return (code == CODE_PASS) || (code == CODE_FAIL);
    endfunction
endpackage

// File: rtl/mbox_apb_master.sv
// Module: mbox_apb_master
// Runs one APB-style transfer per request: a setup cycle, then access cycles
// until pready. Converts a halfword index to a byte address.
// Assumes: req is raised only while idle; ADDR_W >= IDX_W + 1.
module mbox_apb_master
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [HW_W-1:0]   req_wdata,
    output logic              done,
    output logic [HW_W-1:0]   rdata,
    output logic              psel,
    output logic              penable,
    output logic              pwrite,
    output logic [ADDR_W-1:0] paddr,
    output logic [HW_W-1:0]   pwdata,
    input  logic [HW_W-1:0]   prdata,
    input  logic              pready
);
    typedef enum logic [1:0] {B_IDLE, B_SETUP, B_ACCESS} bus_ph_t;
    bus_ph_t ph;

    // Bus phase sequencing and capture of read data on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= B_IDLE;
            psel    <= 1'b0;
            penable <= 1'b0;
            pwrite  <= 1'b0;
            paddr   <= '0;
            pwdata  <= '0;
            done    <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            case (ph)
                B_IDLE: if (req) begin
                    psel   <= 1'b1;
                    pwrite <= req_wr;
                    paddr  <= ADDR_W'({req_idx, 1'b0});
                    pwdata <= req_wdata;
                    ph     <= B_SETUP;
                end
                B_SETUP: begin
                    penable <= 1'b1;
                    ph      <= B_ACCESS;
                end
                B_ACCESS: if (pready) begin
                    psel    <= 1'b0;
                    penable <= 1'b0;
                    done    <= 1'b1;
                    rdata   <= prdata;
                    ph      <= B_IDLE;
                end
                default: ph <= B_IDLE;
            endcase
        end
    end

    // R1
    a_setup_then_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |=> (psel && penable));
    // R1
    a_enable_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> psel);
    // R1
    a_stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pready) |=> (psel && penable && $stable(paddr)
                                          && $stable(pwrite) && $stable(pwdata)));
    // R1
    a_req_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (!psel && !done));
endmodule

// File: rtl/mbox_seq.sv
// Module: mbox_seq
// Handshake sequencer: optional arming writes, poll for a posted message,
// read one or two words, acknowledge, wait for release, close, report.
// Assumes: one outstanding transfer at a time; done is a one-cycle pulse.
module mbox_seq
    import mbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stream_mode,
    input  logic             wait_end,
    input  logic             arm_en,
    input  logic             done,
    input  logic [HW_W-1:0]  rdata,
    output logic             req,
    output logic             req_wr,
    output logic [IDX_W-1:0] req_idx,
    output logic [HW_W-1:0]  req_wdata,
    output logic             start_acc,
    output logic             busy,
    output logic             rpt,
    output logic [MSG_W-1:0] rpt_msg
);
    seq_state_t       st;
    logic             pend;
    logic             stream_q;
    logic             wend_q;
    logic [MSG_W-1:0] shadow;

    assign start_acc = (st == S_IDLE) && !rpt && start;
    assign busy      = (st != S_IDLE) || rpt;
    assign rpt_msg   = shadow;
    assign req       = (st != S_IDLE) && !pend;

    // Transfer descriptor for the current step.
    always_comb begin
        req_wr    = 1'b0;
        req_idx   = IDX_DEV_SHADOW;
        req_wdata = '0;
        case (st)
            S_ARM_H: begin req_wr = 1'b1; req_idx = IDX_HOST_FLAG; req_wdata = 16'd1; end
            S_ARM_D: begin req_wr = 1'b1; req_idx = IDX_DEV_FLAG;  req_wdata = 16'd1; end
            S_RD_LO: req_idx = IDX_MSG_LO;
            S_RD_HI: req_idx = IDX_MSG_HI;
            S_ACK:   begin req_wr = 1'b1; req_idx = IDX_HOST_FLAG; req_wdata = 16'd0; end
            S_FIN:   begin req_wr = 1'b1; req_idx = IDX_HOST_FLAG; req_wdata = 16'd1; end
            default: req_idx = IDX_DEV_SHADOW;
        endcase
    end

    // Step sequencing, message assembly and report pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            pend     <= 1'b0;
            stream_q <= 1'b0;
            wend_q   <= 1'b0;
            shadow   <= '0;
            rpt      <= 1'b0;
        end else begin
            rpt <= 1'b0;
            if (st == S_IDLE) begin
                if (start_acc) begin
                    stream_q <= stream_mode;
                    wend_q   <= wait_end;
                    st       <= arm_en ? S_ARM_H : S_POLL_LO;
                end
            end else if (req) begin
                pend <= 1'b1;
            end else if (done) begin
                pend <= 1'b0;
                case (st)
                    S_ARM_H:   st <= S_ARM_D;
                    S_ARM_D:   st <= S_POLL_LO;
                    S_POLL_LO: if (!rdata[0]) st <= S_RD_LO;
                    S_RD_LO: begin
                        shadow <= {{HW_W{1'b0}}, rdata};
                        st     <= stream_q ? S_RD_HI : S_ACK;
                    end
                    S_RD_HI: begin
                        shadow[MSG_W-1:HW_W] <= rdata;
                        st                   <= S_ACK;
                    end
                    S_ACK:     st <= S_POLL_HI;
                    S_POLL_HI: if (rdata[0]) st <= S_FIN;
                    S_FIN: begin
                        rpt <= 1'b1;
                        st  <= (wend_q && !is_term(shadow[HW_W-1:0])) ? S_POLL_LO : S_IDLE;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    // R2
    poll_lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_POLL_LO && done && rdata[0]) |=> (st == S_POLL_LO));
    // R5
    poll_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_POLL_HI && done && !rdata[0]) |=> (st == S_POLL_HI));
    // R9
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE) |=> ($stable(stream_q) && $stable(wend_q)));
    // R4
    hi_only_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RD_HI) |-> stream_q);
endmodule

// File: rtl/mbox_result.sv
// Module: mbox_result
// Registers each reported message, emits the valid pulse, and keeps the
// training pass/fail flags until the next accepted start.
// Assumes: start_acc and rpt are never high together.
module mbox_result
    import mbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_acc,
    input  logic             rpt,
    input  logic [MSG_W-1:0] rpt_msg,
    output logic [MSG_W-1:0] msg_data,
    output logic             msg_valid,
    output logic             train_pass,
    output logic             train_fail
);
    // Output message register, valid pulse and sticky end-of-training flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_data   <= '0;
            msg_valid  <= 1'b0;
            train_pass <= 1'b0;
            train_fail <= 1'b0;
        end else begin
            msg_valid <= rpt;
            if (rpt) msg_data <= rpt_msg;
            if (start_acc) begin
                train_pass <= 1'b0;
                train_fail <= 1'b0;
            end else if (rpt) begin
                if (rpt_msg[HW_W-1:0] == CODE_PASS) train_pass <= 1'b1;
                if (rpt_msg[HW_W-1:0] == CODE_FAIL) train_fail <= 1'b1;
            end
        end
    end

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> !msg_valid);
    // R7
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(train_pass && train_fail));
    // R7
    pass_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(train_pass) |-> $past(start_acc));
    // R7
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(train_fail) |-> $past(start_acc));
endmodule

// File: rtl/phy_mbox_reader.sv
// Module: phy_mbox_reader (top)
// Host-side reader of the PHY training mailbox over a 16-bit APB-style bus.
// Assumes: ADDR_W holds a halfword index shifted left by one.
module phy_mbox_reader
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stream_mode,
    input  logic              wait_end,
    input  logic              arm_en,
    output logic              psel,
    output logic              penable,
    output logic              pwrite,
    output logic [ADDR_W-1:0] paddr,
    output logic [15:0]       pwdata,
    input  logic [15:0]       prdata,
    input  logic              pready,
    output logic [31:0]       msg_data,
    output logic              msg_valid,
    output logic              busy,
    output logic              train_pass,
    output logic              train_fail
);
    logic             req, req_wr, done, start_acc, rpt;
    logic [IDX_W-1:0] req_idx;
    logic [HW_W-1:0]  req_wdata, rdata;
    logic [MSG_W-1:0] rpt_msg;

    mbox_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .stream_mode(stream_mode),
        .wait_end(wait_end), .arm_en(arm_en), .done(done), .rdata(rdata),
        .req(req), .req_wr(req_wr), .req_idx(req_idx), .req_wdata(req_wdata),
        .start_acc(start_acc), .busy(busy), .rpt(rpt), .rpt_msg(rpt_msg)
    );

    mbox_apb_master #(.ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_idx(req_idx),
        .req_wdata(req_wdata), .done(done), .rdata(rdata), .psel(psel),
        .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .pready(pready)
    );

    mbox_result u_res (
        .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .rpt(rpt),
        .rpt_msg(rpt_msg), .msg_data(msg_data), .msg_valid(msg_valid),
        .train_pass(train_pass), .train_fail(train_fail)
    );
endmodule

// File: tb/phy_mbox_reader_test.sv
module phy_mbox_reader_test;
    localparam int ADDR_W = 24;
    localparam logic [ADDR_W-1:0] A_SHADOW = 24'h1A0008;
    localparam logic [ADDR_W-1:0] A_HOST   = 24'h1A0062;
    localparam logic [ADDR_W-1:0] A_LO     = 24'h1A0064;
    localparam logic [ADDR_W-1:0] A_DEV    = 24'h1A0066;
    localparam logic [ADDR_W-1:0] A_HI     = 24'h1A0068;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic start = 0, stream_mode = 0, wait_end = 0, arm_en = 0;
    logic psel, penable, pwrite, pready;
    logic [ADDR_W-1:0] paddr;
    logic [15:0] pwdata, prdata;
    logic [31:0] msg_data;
    logic msg_valid, busy, train_pass, train_fail;

    phy_mbox_reader #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .stream_mode(stream_mode),
        .wait_end(wait_end), .arm_en(arm_en), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .msg_data(msg_data), .msg_valid(msg_valid), .busy(busy),
        .train_pass(train_pass), .train_fail(train_fail)
    );

    int n_chk = 0, n_bad = 0;

    // PHY mailbox model
    logic [15:0] q_lo [0:15];
    logic [15:0] q_hi [0:15];
    int q_len = 0;
    int q_rd = 0, phase = 0, hold = 0, bad_addr = 0, xfers = 0;
    logic shadow = 1'b1, host_flag = 1'b1, dev_flag = 1'b0;
    logic mdl_clear = 1'b0, mdl_host_init = 1'b1;
    logic [ADDR_W-1:0] log_addr [0:1];
    logic [15:0] log_data [0:1];
    logic log_wr [0:1];
    int wait_pct = 0;

    always_comb begin
        case (paddr)
            A_SHADOW: prdata = {15'h0, shadow};
            A_LO:     prdata = q_lo[q_rd[3:0]];
            A_HI:     prdata = q_hi[q_rd[3:0]];
            A_HOST:   prdata = {15'h0, host_flag};
            A_DEV:    prdata = {15'h0, dev_flag};
            default:  prdata = 16'hDEAD;
        endcase
    end

    always @(negedge clk) pready <= ($urandom_range(0, 99) >= wait_pct);

    always @(posedge clk) begin
        if (mdl_clear) begin
            host_flag <= mdl_host_init; dev_flag <= 1'b0; shadow <= 1'b1;
            phase <= 0; q_rd <= 0; hold <= 2; xfers <= 0; bad_addr <= 0;
        end else begin
            if (psel && penable && pready) begin
                if (xfers < 2) begin
                    log_addr[xfers] <= paddr; log_data[xfers] <= pwdata; log_wr[xfers] <= pwrite;
                end
                xfers <= xfers + 1;
                case (paddr)
                    A_HOST: if (pwrite) host_flag <= pwdata[0];
                    A_DEV:  if (pwrite) dev_flag <= pwdata[0];
                    A_SHADOW, A_LO, A_HI: if (pwrite) bad_addr <= bad_addr + 1;
                    default: bad_addr <= bad_addr + 1;
                endcase
            end
            if (hold > 0) hold <= hold - 1;
            else case (phase)
                0: if (host_flag && q_rd < q_len) begin
                       shadow <= 1'b0; phase <= 1; hold <= $urandom_range(0, 4);
                   end
                1: if (!host_flag) begin shadow <= 1'b1; phase <= 2; end
                2: if (host_flag) begin
                       q_rd <= q_rd + 1; phase <= 0; hold <= $urandom_range(0, 3);
                   end
                default: phase <= 0;
            endcase
        end
    end

    // Output capture
    logic [31:0] rx [0:63];
    int rx_n = 0;
    always @(negedge clk) begin
        if (rst_n && msg_valid) begin
            rx[rx_n % 64] = msg_data;
            rx_n++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_msg(input bit strm, input logic [15:0] lo, input logic [15:0] hi);
        return strm ? {hi, lo} : {16'h0, lo};
    endfunction

    function automatic bit term(input logic [15:0] lo);
        return (lo == 16'h0007) || (lo == 16'h00FF);
    endfunction

    function automatic int exp_count(input bit wend, input int n);
        if (!wend) return 1;
        for (int i = 0; i < n; i++) if (term(q_lo[i])) return i + 1;
        return n;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
        end
    end

    task automatic prep(input int n, input logic host_init);
        q_len = n;
        mdl_host_init = host_init;
        @(negedge clk) mdl_clear = 1'b1;
        @(negedge clk) mdl_clear = 1'b0;
    endtask

    int rx_base;
    task automatic run(input bit strm, input bit wend, input bit arm, input bit poke);
        int cnt;
        rx_base = rx_n;
        @(negedge clk);
        stream_mode = strm; wait_end = wend; arm_en = arm; start = 1'b1;
        @(negedge clk);
        start = 1'b0; stream_mode = ~strm; wait_end = ~wend; arm_en = ~arm;
        // R7: flags cleared once a start is accepted
        chk("R7 flags cleared at start", {30'h0, train_pass, train_fail}, 32'h0);
        cnt = 0;
        while (busy && cnt < 20000) begin
            @(negedge clk); cnt++;
            if (poke && cnt == 12) begin
                start = 1'b1; stream_mode = 1'b1; wait_end = 1'b0;
                @(negedge clk); start = 1'b0; cnt++;
            end
        end
        if (cnt >= 20000) chk("R5 session completes", 32'(cnt), 32'h0);
        repeat (3) @(negedge clk);
    endtask

    task automatic verify(input string tag, input bit strm, input bit wend);
        int ne;
        logic [15:0] last;
        ne = exp_count(wend, q_len);
        chk({tag, " R5 message count"}, 32'(rx_n - rx_base), 32'(ne));
        chk({tag, " R6 mailbox entries consumed"}, 32'(q_rd), 32'(ne));
        for (int i = 0; i < ne && i < rx_n - rx_base; i++)
            chk({tag, strm ? " R4 stream value" : " R3 word value"},
                rx[(rx_base + i) % 64], exp_msg(strm, q_lo[i], q_hi[i]));
        last = q_lo[ne - 1];
        chk({tag, " R7 pass flag"}, {31'h0, train_pass}, {31'h0, last == 16'h0007});
        chk({tag, " R7 fail flag"}, {31'h0, train_fail}, {31'h0, last == 16'h00FF});
        chk({tag, " R1 no foreign address"}, 32'(bad_addr), 32'h0);
        chk({tag, " R9 idle after session"}, {31'h0, busy}, 32'h0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reset outputs", {26'h0, psel, penable, busy, msg_valid, train_pass, train_fail}, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle after reset", {29'h0, psel, busy, msg_valid}, 32'h0);

        // R3: single 16-bit message, upper half zero
        q_lo[0] = 16'h1234; q_hi[0] = 16'hABCD;
        prep(1, 1'b1); run(0, 0, 0, 0); verify("D1", 0, 0);

        // R4: single streaming message
        q_lo[0] = 16'h0042; q_hi[0] = 16'h5A5A;
        prep(1, 1'b1); run(1, 0, 0, 0); verify("D2", 1, 0);

        // R6: loop ends on low word 0x0007 only; 0x1007 is not an end code
        q_lo[0] = 16'h1007; q_hi[0] = 16'h0001;
        q_lo[1] = 16'h0100; q_hi[1] = 16'h0007;
        q_lo[2] = 16'h0007; q_hi[2] = 16'hFFFF;
        q_lo[3] = 16'h0003; q_hi[3] = 16'h0000;
        wait_pct = 40;
        prep(4, 1'b1); run(1, 1, 0, 0); verify("D3", 1, 1);

        // R7 R9: flags clear on next start, start ignored while busy, modes latched
        q_lo[0] = 16'h00FE; q_hi[0] = 16'h1111;
        q_lo[1] = 16'h00FF; q_hi[1] = 16'h2222;
        prep(2, 1'b1); run(0, 1, 0, 1); verify("D4", 0, 1);

        // R7: end code in single-message session still raises the flag
        q_lo[0] = 16'h0007; q_hi[0] = 16'h3333;
        prep(1, 1'b1); run(0, 0, 0, 0); verify("D5", 0, 0);

        // R8: arming writes before the first poll
        q_lo[0] = 16'h0ACE; q_hi[0] = 16'h0BEE;
        prep(1, 1'b0); run(1, 0, 1, 0); verify("D6", 1, 0);
        chk("R8 first transfer host flag write",
            {log_wr[0], log_addr[0], log_data[0][6:0]}, {1'b1, A_HOST, 7'd1});
        chk("R8 second transfer device flag write",
            {log_wr[1], log_addr[1], log_data[1][6:0]}, {1'b1, A_DEV, 7'd1});
        chk("R8 device flag set", {31'h0, dev_flag}, 32'h1);

        // Random sessions
        for (int r = 0; r < 30; r++) begin
            bit strm, wend;
            int n;
            strm = 1'($urandom_range(0, 1));
            wend = 1'($urandom_range(0, 1));
            n = $urandom_range(1, 6);
            for (int i = 0; i < n; i++) begin
                q_lo[i] = 16'($urandom_range(0, 65535));
                q_hi[i] = 16'($urandom_range(0, 65535));
                if (term(q_lo[i])) q_lo[i] = 16'h0500;
            end
            if (wend) q_lo[n - 1] = $urandom_range(0, 1) ? 16'h0007 : 16'h00FF;
            wait_pct = $urandom_range(0, 60);
            prep(n, 1'b1); run(strm, wend, 0, 0);
            verify($sformatf("RND%0d", r), strm, wend);
        end
        summary();
    end
endmodule